// File: doc/BRIEF.md
# Quad I/O Word Read Flash Controller

This controller sits on the host side of a serial NOR flash and fetches data with the word-aligned quad I/O fast read. A request gives a 24-bit even start address and a byte count. The controller lowers chip select and runs the serial clock. It sends the read command on IO0, then the address and a mode byte on all four data lines. It releases the lines for two dummy clocks and then collects data nibbles. Each assembled byte is returned on a valid/ready stream. The flash advances its own address, so one frame returns any number of consecutive bytes.

The mode byte decides whether the flash stays in continuous read. With `cfg_cont` set, the byte sent is 0x20. Its bits 5:4 are binary 10, so the flash keeps the read active, and the controller's next frame starts at the address with no command byte. With `cfg_cont` clear, the byte sent is 0x00 and the next frame carries the command again. A separate mode-reset request forces the flash out of continuous read: it holds all four lines high for eight clocks under chip select. A request with an odd address or a zero count is refused with an error pulse and causes no bus activity.

The serial clock is the system clock divided by the even parameter `DIV`. It idles low. The controller changes its outputs at falling edges and samples at rising edges. If the consumer stalls, the serial clock is held low between data nibbles.

Top module: `qwr_flash_rd`

## Requirements
- R1: When the continuous flag is clear, a read frame begins with command 0xE7, sent MSB first on IO0 over 8 SCLK rising edges, with `io_oe` = 4'b0001 during those edges.
- R2: The 24-bit address follows over 6 rising edges on all four lines (`io_oe` = 4'b1111). The high nibble of each byte goes first, and IO3 carries the nibble's most significant bit.
- R3: A request whose address bit 0 is 1, or whose count is 0, is accepted and answered with `req_err` high for exactly one cycle. Chip select stays high and the continuous flag keeps its value.
- R4: After the address come 2 rising edges carrying the mode byte, high nibble first: 0x20 when `cfg_cont` was 1 at acceptance, 0x00 otherwise.
- R5: Exactly 2 dummy edges follow the mode byte. `io_oe` drops to 4'b0000 on the clock on which SCLK falls to begin the dummy phase, and it stays 0 until chip select rises.
- R6: Exactly `req_len` bytes are read, 2 nibbles per byte with the high nibble first. They are delivered in address order on `rd_valid`/`rd_data`. A stalled `rd_ready` loses no byte and holds `rd_data` stable.
- R7: After a frame whose mode byte was 0x20, the next read frame omits the command. It has 2*len+10 rising edges, against 2*len+18 otherwise.
- R8: A request with `req_mrst` = 1 produces one frame of exactly 8 rising edges with all four lines driven to 1 (`io_oe` = 4'b1111). It clears the continuous flag, so the following read carries the command.
- R9: SCLK is low whenever chip select is high, unstalled rising edges are `DIV` clocks apart, and chip select stays high for at least 2*`DIV` clocks between frames.
- R10: After reset, chip select is high, SCLK is low, `io_oe` is 0, `rd_valid` and `req_err` are 0 and `req_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_mrst | input | 1 | Request is a mode-reset frame instead of a read |
| req_addr | input | 24 | Start byte address (must be even) |
| req_len | input | LEN_W | Number of bytes to read (must be nonzero) |
| cfg_cont | input | 1 | Ask the flash to stay in continuous read after this frame |
| req_err | output | 1 | One-cycle pulse for a refused request |
| rd_valid | output | 1 | Read byte available |
| rd_ready | input | 1 | Consumer accepts the byte |
| rd_data | output | 8 | Read byte |
| flash_cs_n | output | 1 | Flash chip select, active low |
| flash_sclk | output | 1 | Flash serial clock |
| io_out | output | 4 | Values driven onto IO3..IO0 |
| io_oe | output | 4 | Per-line output enable |
| io_in | input | 4 | Values read from IO3..IO0 |

## Verification
Chip select falls on the clock edge that accepts a request. The first SCLK rise comes `DIV`/2 clocks later, and each following unstalled rise comes `DIV` clocks after the previous one. A byte appears on `rd_valid` at the edge where SCLK rises with its low nibble, and `req_err` is high during the single cycle after the accepting edge. The bench drives inputs and samples outputs at falling system-clock edges. A flash model in the bench records every nibble and enable value at each SCLK rise and drives data after each SCLK fall. Each frame is judged after chip select rises, against edge counts and field positions worked out arithmetically in the bench.

// File: rtl/qwr_pkg.sv
package qwr_pkg;

  typedef enum logic [2:0] {
    PH_OPC, PH_ADR, PH_MODE, PH_DUMMY, PH_DATA, PH_MRST
  } qwr_ph_e;

  localparam logic [7:0] QWR_OPCODE    = 8'hE7;
  localparam logic [7:0] QWR_MODE_KEEP = 8'h20;
  localparam logic [7:0] QWR_MODE_DROP = 8'h00;
  localparam int unsigned QWR_OPC_CYC   = 8;
  localparam int unsigned QWR_ADR_CYC   = 6;
  localparam int unsigned QWR_MODE_CYC  = 2;
  localparam int unsigned QWR_DUMMY_CYC = 2;
  localparam int unsigned QWR_MRST_CYC  = 8;

  // SCLK cycles spent on the command byte
  function automatic int unsigned hdr_len(input logic skip);
    return skip ? 0 : QWR_OPC_CYC;
  endfunction

  // phase of a given SCLK cycle inside a read frame
  function automatic qwr_ph_e phase_at(input int unsigned cyc, input logic skip);
    int unsigned b;
    b = hdr_len(skip);
    if (cyc < b) return PH_OPC;
    if (cyc < b + QWR_ADR_CYC) return PH_ADR;
    if (cyc < b + QWR_ADR_CYC + QWR_MODE_CYC) return PH_MODE;
    if (cyc < b + QWR_ADR_CYC + QWR_MODE_CYC + QWR_DUMMY_CYC) return PH_DUMMY;
    return PH_DATA;
  endfunction

  // total SCLK cycles of a read frame
  function automatic int unsigned frame_cycles(input logic skip, input int unsigned nbytes);
    return hdr_len(skip) + QWR_ADR_CYC + QWR_MODE_CYC + QWR_DUMMY_CYC + 2 * nbytes;
  endfunction

  // nibble driven during a given SCLK cycle
  function automatic logic [3:0] tx_nibble(input int unsigned cyc, input logic skip,
                                           input logic [23:0] addr, input logic [7:0] mode);
    int unsigned b;
    int unsigned k;
    b = hdr_len(skip);
    case (phase_at(cyc, skip))
      PH_OPC:  return {3'b000, QWR_OPCODE[3'(7 - cyc)]};
      PH_ADR: begin
        k = cyc - b;
        return 4'(addr >> (20 - 4 * k));
      end
      PH_MODE: begin
        k = cyc - b - QWR_ADR_CYC;
        return 4'(mode >> (4 - 4 * k));
      end
      default: return 4'h0;
    endcase
  endfunction

  function automatic logic [3:0] tx_oe(input qwr_ph_e ph);
    case (ph)
      PH_OPC:                   return 4'b0001;
      PH_ADR, PH_MODE, PH_MRST: return 4'b1111;
      default:                  return 4'b0000;
    endcase
  endfunction

  function automatic logic mode_keeps(input logic [7:0] m);
    return m[5:4] == 2'b10;
  endfunction

endpackage

// File: rtl/qwr_sclk_gen.sv
module qwr_sclk_gen #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic stall,
  output logic sclk,
  output logic rise,
  output logic fall
);
  localparam int HALF = DIV / 2;
  localparam int CW   = (HALF > 1) ? $clog2(HALF) : 1;

  logic [CW-1:0] cnt_q;
  logic          frozen;
  logic          tick;

  assign frozen = stall && !sclk;
  assign tick   = run && !frozen && (cnt_q == CW'(HALF - 1));
  assign rise   = tick && !sclk;
  assign fall   = tick && sclk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      sclk  <= 1'b0;
    end else if (!run) begin
      cnt_q <= '0;
      sclk  <= 1'b0;
    end else if (frozen) begin
      cnt_q <= cnt_q;
    end else if (tick) begin
      cnt_q <= '0;
      sclk  <= ~sclk;
    end else begin
      cnt_q <= cnt_q + CW'(1);
    end
  end

  // R9
  sclk_park_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !sclk);

endmodule

// File: rtl/qwr_rx_pack.sv
module qwr_rx_pack (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       nib_en,
  input  logic [3:0] nib,
  output logic       push,
  output logic [7:0] byte_o
);
  logic       half_q;
  logic [3:0] hi_q;

  assign push   = nib_en && half_q;
  assign byte_o = {hi_q, nib};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half_q <= 1'b0;
      hi_q   <= 4'h0;
    end else if (clr) begin
      half_q <= 1'b0;
    end else if (nib_en) begin
      half_q <= ~half_q;
      if (!half_q) hi_q <= nib;
    end
  end

  // R6
  pair_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> !half_q);

endmodule

// File: rtl/qwr_flash_rd.sv
module qwr_flash_rd #(
  parameter int DIV   = 4,
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_mrst,
  input  logic [23:0]      req_addr,
  input  logic [LEN_W-1:0] req_len,
  input  logic             cfg_cont,
  output logic             req_err,
  output logic             rd_valid,
  input  logic             rd_ready,
  output logic [7:0]       rd_data,
  output logic             flash_cs_n,
  output logic             flash_sclk,
  output logic [3:0]       io_out,
  output logic [3:0]       io_oe,
  input  logic [3:0]       io_in
);
  import qwr_pkg::*;

  localparam int CYC_W   = LEN_W + 2;
  localparam int GAP_CYC = 2 * DIV;
  localparam int GW      = $clog2(GAP_CYC) + 1;

  typedef enum logic [2:0] {ST_IDLE, ST_XFER, ST_MRST, ST_GAP} qwr_st_e;

  qwr_st_e          st_q;
  logic             cs_n_q;
  logic [3:0]       io_out_q;
  logic [3:0]       io_oe_q;
  logic [CYC_W-1:0] cyc_q;
  logic [23:0]      addr_q;
  logic [LEN_W-1:0] len_q;
  logic [7:0]       mode_q;
  logic             skip_q;
  logic             cont_q;
  logic [GW-1:0]    gap_q;
  logic             err_q;
  logic             out_vld_q;
  logic [7:0]       out_dat_q;

  // named internal events
  logic             sclk_rise;
  logic             sclk_fall;
  logic             sclk_run;
  logic             sclk_hold;
  qwr_ph_e          cur_ph;
  logic [CYC_W-1:0] nxt_cyc;
  logic             frame_done;
  logic             rx_nib_en;
  logic             byte_push;
  logic [7:0]       byte_val;
  logic             bad_req;
  logic [7:0]       mode_sel;

  assign nxt_cyc   = cyc_q + CYC_W'(1);
  assign cur_ph    = (st_q == ST_MRST) ? PH_MRST : phase_at(32'(cyc_q), skip_q);
  assign frame_done = (st_q == ST_MRST) ? (32'(nxt_cyc) == QWR_MRST_CYC)
                                        : (32'(nxt_cyc) == frame_cycles(skip_q, 32'(len_q)));
  assign sclk_run  = (st_q == ST_XFER) || (st_q == ST_MRST);
  assign sclk_hold = (st_q == ST_XFER) && (cur_ph == PH_DATA) && out_vld_q && !rd_ready;
  assign rx_nib_en = (st_q == ST_XFER) && sclk_rise && (cur_ph == PH_DATA);
  assign bad_req   = req_addr[0] || (req_len == '0);
  assign mode_sel  = cfg_cont ? QWR_MODE_KEEP : QWR_MODE_DROP;

  qwr_sclk_gen #(.DIV(DIV)) u_sclk (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (sclk_run),
    .stall (sclk_hold),
    .sclk  (flash_sclk),
    .rise  (sclk_rise),
    .fall  (sclk_fall)
  );

  qwr_rx_pack u_rx (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (st_q == ST_IDLE),
    .nib_en (rx_nib_en),
    .nib    (io_in),
    .push   (byte_push),
    .byte_o (byte_val)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      cs_n_q   <= 1'b1;
      io_out_q <= 4'h0;
      io_oe_q  <= 4'h0;
      cyc_q    <= '0;
      addr_q   <= '0;
      len_q    <= '0;
      mode_q   <= '0;
      skip_q   <= 1'b0;
      cont_q   <= 1'b0;
      gap_q    <= '0;
      err_q    <= 1'b0;
    end else begin
      err_q <= 1'b0;
      case (st_q)
        ST_IDLE: if (req_valid) begin
          if (req_mrst) begin
            st_q     <= ST_MRST;
            cs_n_q   <= 1'b0;
            cyc_q    <= '0;
            io_out_q <= 4'hF;
            io_oe_q  <= tx_oe(PH_MRST);
          end else if (bad_req) begin
            err_q <= 1'b1;
          end else begin
            st_q     <= ST_XFER;
            cs_n_q   <= 1'b0;
            cyc_q    <= '0;
            addr_q   <= req_addr;
            len_q    <= req_len;
            mode_q   <= mode_sel;
            skip_q   <= cont_q;
            io_out_q <= tx_nibble(0, cont_q, req_addr, mode_sel);
            io_oe_q  <= tx_oe(phase_at(0, cont_q));
          end
        end
        ST_XFER, ST_MRST: if (sclk_fall) begin
          if (frame_done) begin
            st_q     <= ST_GAP;
            cs_n_q   <= 1'b1;
            io_out_q <= 4'h0;
            io_oe_q  <= 4'h0;
            gap_q    <= '0;
            cont_q   <= (st_q == ST_XFER) ? mode_keeps(mode_q) : 1'b0;
          end else if (st_q == ST_XFER) begin
            cyc_q    <= nxt_cyc;
            io_out_q <= tx_nibble(32'(nxt_cyc), skip_q, addr_q, mode_q);
            io_oe_q  <= tx_oe(phase_at(32'(nxt_cyc), skip_q));
          end else begin
            cyc_q <= nxt_cyc;
          end
        end
        ST_GAP: begin
          gap_q <= gap_q + GW'(1);
          if (gap_q == GW'(GAP_CYC - 1)) st_q <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_vld_q <= 1'b0;
      out_dat_q <= 8'h00;
    end else if (byte_push) begin
      out_vld_q <= 1'b1;
      out_dat_q <= byte_val;
    end else if (rd_ready) begin
      out_vld_q <= 1'b0;
    end
  end

  assign req_ready  = (st_q == ST_IDLE);
  assign req_err    = err_q;
  assign rd_valid   = out_vld_q;
  assign rd_data    = out_dat_q;
  assign flash_cs_n = cs_n_q;
  assign io_out     = io_out_q;
  assign io_oe      = io_oe_q;

  // clocks chip select has been high, saturating
  logic [15:0] hi_run_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               hi_run_q <= 16'hFFFF;
    else if (!cs_n_q)         hi_run_q <= 16'h0;
    else if (hi_run_q != 16'hFFFF) hi_run_q <= hi_run_q + 16'h1;
  end

  // R9
  sclk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flash_cs_n |-> !flash_sclk);

  // R9
  cs_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flash_cs_n) |-> (hi_run_q >= 16'(GAP_CYC)));

  // R5
  oe_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flash_cs_n |-> (io_oe == 4'h0));

  // R5
  oe_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((|$past(io_oe)) && !(|io_oe) && !flash_cs_n) |-> ($past(flash_sclk) && !flash_sclk));

  // R6
  stream_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));

  // R3
  err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_err |-> (flash_cs_n && req_ready));

endmodule

// File: tb/qwr_flash_rd_bench.sv
`timescale 1ns/1ps
module qwr_flash_rd_bench;
  localparam int DIV   = 4;
  localparam int LEN_W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_mrst = 1'b0;
  logic [23:0] req_addr = '0;
  logic [LEN_W-1:0] req_len = '0;
  logic cfg_cont = 1'b0;
  logic rd_ready = 1'b1;
  logic [3:0] io_in = 4'h0;
  logic req_ready, req_err, rd_valid, flash_cs_n, flash_sclk;
  logic [7:0] rd_data;
  logic [3:0] io_out, io_oe;

  always #4 clk = ~clk;

  qwr_flash_rd #(.DIV(DIV), .LEN_W(LEN_W)) u_qwr_flash_rd (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_mrst(req_mrst), .req_addr(req_addr), .req_len(req_len), .cfg_cont(cfg_cont),
    .req_err(req_err), .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
    .flash_cs_n(flash_cs_n), .flash_sclk(flash_sclk), .io_out(io_out), .io_oe(io_oe),
    .io_in(io_in)
  );

  int checks = 0;
  int fails = 0;
  int clk_ctr = 0;
  int rdy_mode = 0;
  logic exp_cont = 1'b0;

  function automatic logic [7:0] fdata(input logic [23:0] a);
    return (a[7:0] * 8'd29) ^ a[15:8] ^ {a[19:16], a[23:20]} ^ 8'hC3;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // ---------------- flash model ----------------
  logic [3:0] rec_io [0:1023];
  logic [3:0] rec_oe [0:1023];
  int rcnt = 0;
  int last_rises = 0;
  int frames = 0;
  int min_per = 1 << 30;
  int last_rise_clk = -1;
  logic m_cont = 1'b0;
  logic [23:0] m_addr = '0;
  logic [7:0] m_mode = '0;

  always @(posedge flash_sclk or negedge flash_cs_n) begin
    if (!flash_sclk) begin
      rcnt = 0;
      min_per = 1 << 30;
      last_rise_clk = -1;
    end else if (!flash_cs_n) begin
      int off;
      off = m_cont ? 0 : 8;
      rec_io[rcnt] = io_out;
      rec_oe[rcnt] = io_oe;
      if (rcnt >= off && rcnt < off + 6) m_addr = {m_addr[19:0], io_out};
      else if (rcnt >= off + 6 && rcnt < off + 8) m_mode = {m_mode[3:0], io_out};
      if (last_rise_clk >= 0 && (clk_ctr - last_rise_clk) < min_per)
        min_per = clk_ctr - last_rise_clk;
      last_rise_clk = clk_ctr;
      rcnt++;
    end
  end

  always @(negedge flash_sclk) begin
    if (!flash_cs_n) begin
      int off;
      int k;
      logic [7:0] b;
      off = m_cont ? 0 : 8;
      if (rcnt >= off + 10) begin
        k = rcnt - off - 10;
        b = fdata(m_addr + 24'(k / 2));
        io_in <= (k % 2 == 0) ? b[7:4] : b[3:0];
      end
    end
  end

  always @(posedge flash_cs_n) begin
    bit allf;
    int off;
    allf = 1'b1;
    off = m_cont ? 0 : 8;
    for (int i = 0; i < rcnt; i++) if (rec_io[i] != 4'hF) allf = 1'b0;
    if (rcnt == 8 && allf) m_cont = 1'b0;
    else if (rcnt >= off + 8) m_cont = (m_mode[5:4] == 2'b10);
    last_rises = rcnt;
    frames++;
  end

  // ---------------- stream consumer and timing monitors ----------------
  logic [7:0] got [0:4095];
  int ng = 0;
  int hi_cnt = 1 << 20;
  int min_gap = 1 << 20;

  always @(negedge clk) begin
    case (rdy_mode)
      0: rd_ready = 1'b1;
      1: rd_ready = clk_ctr[0];
      default: rd_ready = (clk_ctr % 5) == 0;
    endcase
    if (rd_valid && rd_ready) begin
      got[ng] = rd_data;
      ng++;
    end
    if (rst_n) begin
      if (flash_cs_n) hi_cnt++;
      else if (hi_cnt != 0) begin
        if (hi_cnt < min_gap) min_gap = hi_cnt;
        hi_cnt = 0;
      end
    end
  end

  int done_flag = 0;
  always @(posedge clk) begin
    clk_ctr++;
    if (clk_ctr > 150000 && done_flag == 0) begin
      $display("FAIL watchdog actual=%0d expected=%0d", clk_ctr, 150000);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks + 1, fails + 1);
      $finish;
    end
  end

  // ---------------- stimulus tasks ----------------
  task automatic issue(input logic [23:0] a, input int n, input logic c, input logic mr);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1;
    req_addr = a;
    req_len = LEN_W'(n);
    cfg_cont = c;
    req_mrst = mr;
    @(negedge clk);
    req_valid = 1'b0;
    req_mrst = 1'b0;
  endtask

  task automatic do_read(input logic [23:0] a, input int n, input logic c);
    int f0, n0, base, nr;
    logic skip;
    logic [7:0] op, md;
    logic [23:0] ad;
    bit oe_ok;
    f0 = frames;
    n0 = ng;
    skip = exp_cont;
    issue(a, n, c, 1'b0);
    while (!(frames == f0 + 1 && ng >= n0 + n && req_ready)) @(negedge clk);
    base = skip ? 0 : 8;
    nr = base + 10 + 2 * n;
    // R7: edge count shows whether the command was sent
    chk(last_rises == nr, skip ? "R7 rises (no command)" : "R7 rises (with command)", last_rises, nr);
    if (!skip) begin
      op = '0;
      oe_ok = 1'b1;
      for (int i = 0; i < 8; i++) begin
        op = {op[6:0], rec_io[i][0]};
        if (rec_oe[i] != 4'b0001) oe_ok = 1'b0;
      end
      chk(op == 8'hE7, "R1 command byte", op, 8'hE7);
      chk(oe_ok, "R1 command enables", 0, 1);
    end
    ad = '0;
    oe_ok = 1'b1;
    for (int i = 0; i < 6; i++) begin
      ad = {ad[19:0], rec_io[base + i]};
      if (rec_oe[base + i] != 4'hF) oe_ok = 1'b0;
    end
    chk(ad == a, "R2 address", ad, a);
    chk(oe_ok, "R2 address enables", 0, 1);
    md = {rec_io[base + 6], rec_io[base + 7]};
    chk(md == (c ? 8'h20 : 8'h00), "R4 mode byte", md, c ? 8'h20 : 8'h00);
    oe_ok = 1'b1;
    for (int i = base + 8; i < nr; i++) if (rec_oe[i] != 4'h0) oe_ok = 1'b0;
    chk(oe_ok, "R5 lines released in dummy and data", 0, 1);
    for (int i = 0; i < n; i++)
      chk(got[n0 + i] == fdata(a + 24'(i)), "R6 data byte", got[n0 + i], fdata(a + 24'(i)));
    chk(ng == n0 + n, "R6 byte count", ng - n0, n);
    chk(min_per == DIV, "R9 sclk period", min_per, DIV);
    exp_cont = c;
  endtask

  task automatic do_err(input logic [23:0] a, input int n);
    int f0;
    f0 = frames;
    issue(a, n, 1'b1, 1'b0);
    chk(req_err == 1'b1, "R3 error pulse", req_err, 1);
    @(negedge clk);
    chk(req_err == 1'b0, "R3 error pulse width", req_err, 0);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (!flash_cs_n) f0 = -1;
    end
    chk(frames == f0, "R3 no bus activity", frames, f0);
  endtask

  task automatic do_mrst();
    int f0;
    bit ok;
    f0 = frames;
    issue(24'h0, 1, 1'b0, 1'b1);
    while (!(frames == f0 + 1 && req_ready)) @(negedge clk);
    chk(last_rises == 8, "R8 mode-reset length", last_rises, 8);
    ok = 1'b1;
    for (int i = 0; i < 8; i++) if (rec_io[i] != 4'hF || rec_oe[i] != 4'hF) ok = 1'b0;
    chk(ok, "R8 lines all high", 0, 1);
    exp_cont = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(flash_cs_n == 1'b1, "R10 cs high", flash_cs_n, 1);
    chk(flash_sclk == 1'b0, "R10 sclk low", flash_sclk, 0);
    chk(io_oe == 4'h0, "R10 oe off", io_oe, 0);
    chk(rd_valid == 1'b0 && req_err == 1'b0, "R10 outputs idle", rd_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R10 ready", req_ready, 1);

    do_read(24'h000100, 1, 1'b0);
    do_read(24'h123456, 2, 1'b1);
    do_read(24'h123458, 3, 1'b1);
    do_read(24'h00FFFE, 4, 1'b0);
    do_read(24'h000010, 2, 1'b0);
    for (int m = 0; m < 3; m++) begin
      rdy_mode = m;
      for (int i = 0; i < 6; i++)
        do_read(24'h0A0000 + 24'(i * 24'h1236), 1 + (i % 4), (i % 3) != 0);
    end
    rdy_mode = 0;
    // R3 refusal keeps the continuous flag
    do_read(24'h000300, 2, 1'b1);
    do_err(24'h000101, 2);
    do_err(24'h000200, 0);
    do_read(24'h000302, 1, 1'b1);
    // R8 from continuous and from normal state
    do_mrst();
    do_read(24'h000400, 2, 1'b0);
    do_mrst();
    do_read(24'h000500, 1, 1'b1);
    rdy_mode = 2;
    do_read(24'h7FFFF0, 20, 1'b1);
    rdy_mode = 1;
    do_read(24'hFFFFFC, 6, 1'b0);
    rdy_mode = 0;
    do_read(24'h000040, 1, 1'b0);
    chk(min_gap >= 2 * DIV, "R9 chip select gap", min_gap, 2 * DIV);
    done_flag = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule